// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter Pair

The block holds two timer/counter channels. Each channel is made of a low count byte and a high count byte. A mode byte gives each channel a 4-bit field that sets four things: whether an external gate input must be high for counting, whether the count source is the machine-cycle tick or the channel's event tick, and one of four counter shapes. The shapes are 13-bit, 16-bit, 8-bit with hardware reload, and split. A control byte holds one run bit and one overflow flag per channel. Software writes the run bits. Hardware sets a flag when its counter wraps from all ones to zero.

A byte-wide register port reads and writes six registers: the mode byte, the control byte and the four count bytes. The machine-cycle tick and the per-channel event ticks come from outside the block, already qualified: one tick is one count step. When channel 0 is split, its high byte becomes a second 8-bit timer. That timer uses channel 1's run bit and overflow flag. Channel 1 then keeps counting without its run bit and raises no flag.

Top module: `dual_tmr_cnt`

## Requirements
- R1: After reset, all six registers read 0x00 and both flag outputs are low.
- R2: The register addresses are: 0 mode, 1 control, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high. The mode byte bits 3..0 configure channel 0 and bits 7..4 configure channel 1, each as {gate, source, mode[1:0]} from MSB to LSB, with source 1 meaning event tick. Control bits are 4 run0, 5 flag0, 6 run1, 7 flag1. Control bits 3..0 read 0 and ignore writes. The mode and count bytes read back what was written.
- R3: A channel steps only when its run bit is 1, its gate bit is 0 or its gate input is 1, and its selected source ticks. The source is mc_tick_i when the source bit is 0 and ev_tick_i[ch] when it is 1.
- R4: Mode 0 counts with 13 bits: the high byte above the low byte's bits 4..0. The carry passes from low bit 4 into the high byte. Low bits 7..5 keep their written value. The flag sets when the count wraps from 0x1FFF to 0.
- R5: Mode 1 counts with the full 16 bits {high, low}. The flag sets when the count wraps from 0xFFFF to 0.
- R6: Mode 2 counts in the low byte only. When a step finds the low byte at 0xFF, the flag sets and the low byte is loaded from the high byte.
- R7: In mode 3, channel 0's low byte is an 8-bit counter under channel 0's run, gate and source, and it sets flag0. Channel 0's high byte steps on mc_tick_i while run1 is 1, and sets flag1 when it wraps.
- R8: Channel 1 in mode 3 holds its count bytes unchanged.
- R9: While channel 0 is in mode 3, channel 1 counts regardless of run1, and its wrap sets no flag.
- R10: If hardware sets a flag in the same cycle that software writes the control byte, the flag reads 1 afterwards. At any other time a control write sets or clears the flag.
- R11: A write to a count byte in the same cycle as a step stores the written value, and that step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| mc_tick_i | input | 1 | Machine-cycle tick |
| ev_tick_i | input | 2 | Per-channel qualified event tick |
| gate_in_i | input | 2 | Per-channel gate input |
| flag_o | output | 2 | Overflow flags {flag1, flag0} |

## Verification
Each counter shape is preloaded just below its wrap point. Reading back the count bytes then shows which bits carry and what the counter wraps to:
- Mode 0 shows the 13-bit boundary, with bits 7..5 of the low byte left untouched.
- Mode 1 shows the full 16-bit wrap.
- Mode 2 shows the reload from the high byte.
- Split mode shows that the two halves count independently, each with its own run bit and flag.

Gate-low, run-off and wrong-source tick patterns separate the terms of the enable condition. Writes that land in the same cycle as a step or a flag set show which side wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_AW = 3;

  typedef enum logic [1:0] {
    MD_13B    = 2'd0,
    MD_16B    = 2'd1,
    MD_RELOAD = 2'd2,
    MD_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ev_src;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  localparam logic [TMR_AW-1:0] ADR_MODE = 3'd0;
  localparam logic [TMR_AW-1:0] ADR_CTRL = 3'd1;
  localparam logic [TMR_AW-1:0] ADR_LO0  = 3'd2;
endpackage

// File: rtl/tmr_gate.sv
module tmr_gate (
  input  logic run_i,
  input  logic gate_i,
  input  logic gin_i,
  input  logic ev_src_i,
  input  logic mc_tick_i,
  input  logic ev_tick_i,
  output logic en_o
);
  assign en_o = run_i && (!gate_i || gin_i) && (ev_src_i ? ev_tick_i : mc_tick_i);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              inc_lo_i,
  input  logic              inc_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  localparam int C13_W = BYTE_W + PRE_W;
  localparam int C16_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic [C13_W-1:0]  c13;
  logic [C16_W-1:0]  c16;
  logic              step_pair;

  assign c13       = {hi_q, lo_q[PRE_W-1:0]} + C13_W'(1);
  assign c16       = {hi_q, lo_q} + C16_W'(1);
  // coupled shapes: a write to either byte drops the step
  assign step_pair = inc_lo_i && !wr_lo_i && !wr_hi_i;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    unique case (mode_i)
      MD_13B: if (step_pair) begin
        lo_d     = {lo_q[BYTE_W-1:PRE_W], c13[PRE_W-1:0]};
        hi_d     = c13[C13_W-1:PRE_W];
        ovf_lo_o = &{hi_q, lo_q[PRE_W-1:0]};
      end
      MD_16B: if (step_pair) begin
        {hi_d, lo_d} = c16;
        ovf_lo_o     = &{hi_q, lo_q};
      end
      MD_RELOAD: if (inc_lo_i && !wr_lo_i) begin
        if (&lo_q) begin
          lo_d     = hi_q;
          ovf_lo_o = 1'b1;
        end else begin
          lo_d = lo_q + BYTE_W'(1);
        end
      end
      MD_SPLIT: begin
        if (inc_lo_i && !wr_lo_i) begin
          lo_d     = lo_q + BYTE_W'(1);
          ovf_lo_o = &lo_q;
        end
        if (inc_hi_i && !wr_hi_i) begin
          hi_d     = hi_q + BYTE_W'(1);
          ovf_hi_o = &hi_q;
        end
      end
    endcase
    if (wr_lo_i) lo_d = wr_data_i;
    if (wr_hi_i) hi_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_q == $past(wr_data_i)); // R11
  AST_RELOAD_FROM_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_RELOAD) && inc_lo_i && !wr_lo_i && (&lo_q) |=> lo_q == $past(hi_q)); // R6
  AST_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_13B) && !wr_lo_i |=> lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W])); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_lo_i && !inc_hi_i && !wr_lo_i && !wr_hi_i |=> $stable(lo_q) && $stable(hi_q)); // R3
endmodule

// File: rtl/dual_tmr_cnt.sv
module dual_tmr_cnt
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TMR_AW-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [TMR_AW-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              mc_tick_i,
  input  logic [1:0]        ev_tick_i,
  input  logic [1:0]        gate_in_i,
  output logic [1:0]        flag_o
);
  localparam int N_CH = 2;

  logic [N_CH*CFG_W-1:0] mode_q;
  logic [N_CH-1:0]       run_q, flag_q, flag_set;
  logic [N_CH-1:0]       run_eff, en, inc_lo, inc_hi, ovf_lo, ovf_hi, wr_lo, wr_hi;
  logic [BYTE_W-1:0]     lo_w [N_CH];
  logic [BYTE_W-1:0]     hi_w [N_CH];
  chan_cfg_t             cfg  [N_CH];
  logic                  split0, hold1, ctrl_wr;

  assign split0  = cfg[0].mode == MD_SPLIT;
  assign hold1   = cfg[1].mode == MD_SPLIT;
  assign ctrl_wr = wr_en_i && (wr_addr_i == ADR_CTRL);

  // channel 0 split borrows run1, so channel 1 free-runs
  assign run_eff[0] = run_q[0];
  assign run_eff[1] = split0 ? 1'b1 : run_q[1];
  assign inc_lo[0]  = en[0];
  assign inc_lo[1]  = en[1] && !hold1;
  assign inc_hi[0]  = split0 && run_q[1] && mc_tick_i;
  assign inc_hi[1]  = 1'b0;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [TMR_AW-1:0] LO_ADR = TMR_AW'(int'(ADR_LO0) + 2 * c);
    localparam logic [TMR_AW-1:0] HI_ADR = TMR_AW'(int'(ADR_LO0) + 2 * c + 1);

    assign cfg[c]   = mode_q[c*CFG_W +: CFG_W];
    assign wr_lo[c] = wr_en_i && (wr_addr_i == LO_ADR);
    assign wr_hi[c] = wr_en_i && (wr_addr_i == HI_ADR);

    tmr_gate u_gate (
      .run_i    (run_eff[c]),
      .gate_i   (cfg[c].gate),
      .gin_i    (gate_in_i[c]),
      .ev_src_i (cfg[c].ev_src),
      .mc_tick_i(mc_tick_i),
      .ev_tick_i(ev_tick_i[c]),
      .en_o     (en[c])
    );

    tmr_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (cfg[c].mode),
      .inc_lo_i (inc_lo[c]),
      .inc_hi_i (inc_hi[c]),
      .wr_lo_i  (wr_lo[c]),
      .wr_hi_i  (wr_hi[c]),
      .wr_data_i(wr_data_i),
      .lo_o     (lo_w[c]),
      .hi_o     (hi_w[c]),
      .ovf_lo_o (ovf_lo[c]),
      .ovf_hi_o (ovf_hi[c])
    );
  end

  assign flag_set[0] = ovf_lo[0];
  assign flag_set[1] = split0 ? ovf_hi[0] : ovf_lo[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en_i && (wr_addr_i == ADR_MODE)) mode_q <= wr_data_i;
      if (ctrl_wr) begin
        run_q  <= {wr_data_i[6], wr_data_i[4]};
        flag_q <= {wr_data_i[7], wr_data_i[5]} | flag_set;
      end else begin
        flag_q <= flag_q | flag_set;
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      3'd0:    rd_data_o = mode_q;
      3'd1:    rd_data_o = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'h0};
      3'd2:    rd_data_o = lo_w[0];
      3'd3:    rd_data_o = hi_w[0];
      3'd4:    rd_data_o = lo_w[1];
      3'd5:    rd_data_o = hi_w[1];
      default: rd_data_o = '0;
    endcase
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[0] && !ctrl_wr |=> flag_q[0]); // R10
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_lo[0] |=> flag_q[0]); // R10
  AST_HOLD_CH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold1 && !wr_lo[1] && !wr_hi[1] |=> $stable(lo_w[1]) && $stable(hi_w[1])); // R8
  AST_SPLIT_NO_FLAG1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split0 && !ctrl_wr && !flag_q[1] && !ovf_hi[0] |=> !flag_q[1]); // R9
endmodule

// File: tb/tb_dual_tmr_cnt.sv
`timescale 1ns/1ps
module tb_dual_tmr_cnt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       mc_tick = 1'b0;
  logic [1:0] ev_tick = '0;
  logic [1:0] gate_in = '0;
  logic [1:0] flags;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [2:0] addr;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];
  item_t mon_it;

  always #4 clk = ~clk;

  dual_tmr_cnt dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mc_tick_i(mc_tick), .ev_tick_i(ev_tick), .gate_in_i(gate_in), .flag_o(flags)
  );

  // monitor: pops expected items and compares against the read port
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      mon_it = sb_q.pop_front();
      rd_addr = mon_it.addr;
      #1;
      n_chk++;
      if (rd_data !== mon_it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", mon_it.req, mon_it.addr, rd_data, mon_it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string req);
    item_t it;
    it.addr = a; it.exp = e; it.req = req;
    sb_q.push_back(it);
    @(negedge clk); #3;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    mc_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 mc_tick = 1'b0;
  endtask

  task automatic evs(input int ch, input int n);
    @(posedge clk); #1;
    ev_tick[ch] = 1'b1;
    repeat (n) @(posedge clk);
    #1 ev_tick[ch] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) expect_rd(3'(a), 8'h00, "R1");
    n_chk++;
    if (flags !== 2'b00) begin n_fail++; $display("FAIL R1 flags actual=%b expected=00", flags); end

    // R2 map and readback
    wr(3'd0, 8'hA5); expect_rd(3'd0, 8'hA5, "R2");
    wr(3'd1, 8'hFF); expect_rd(3'd1, 8'hF0, "R2");
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    wr(3'd5, 8'h3C); expect_rd(3'd5, 8'h3C, "R2");

    // R5 16-bit wrap, channel 0
    wr(3'd0, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    ticks(3);
    expect_rd(3'd2, 8'h01, "R5"); expect_rd(3'd3, 8'h00, "R5"); expect_rd(3'd1, 8'h30, "R5");
    wr(3'd1, 8'h00);

    // R3 gate, run and source
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h10);
    ticks(5); expect_rd(3'd2, 8'h00, "R3 gate low");
    gate_in[0] = 1'b1;
    ticks(5); expect_rd(3'd2, 8'h05, "R3 gate high");
    wr(3'd1, 8'h00);
    ticks(3); expect_rd(3'd2, 8'h05, "R3 run off");
    wr(3'd0, 8'h0D); wr(3'd1, 8'h10);
    ticks(4); expect_rd(3'd2, 8'h05, "R3 event src ignores mc tick");
    evs(0, 3); expect_rd(3'd2, 8'h08, "R3 event src");
    wr(3'd1, 8'h00); gate_in[0] = 1'b0;

    // R4 13-bit, channel 1
    wr(3'd0, 8'h00); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF); wr(3'd1, 8'h40);
    ticks(3);
    expect_rd(3'd4, 8'hE1, "R4 wrap keeps bits 7..5");
    expect_rd(3'd5, 8'h00, "R4 wrap");
    expect_rd(3'd1, 8'hC0, "R4 flag1");
    wr(3'd4, 8'h1F); wr(3'd5, 8'h05);
    ticks(1);
    expect_rd(3'd4, 8'h00, "R4 carry lo"); expect_rd(3'd5, 8'h06, "R4 carry hi");
    wr(3'd1, 8'h00);

    // R6 reload
    wr(3'd0, 8'h02); wr(3'd3, 8'h80); wr(3'd2, 8'hFE); wr(3'd1, 8'h10);
    ticks(4);
    expect_rd(3'd2, 8'h82, "R6"); expect_rd(3'd3, 8'h80, "R6"); expect_rd(3'd1, 8'h30, "R6");
    wr(3'd1, 8'h00);

    // R7 split
    wr(3'd0, 8'h03); wr(3'd2, 8'hFF); wr(3'd3, 8'hFE); wr(3'd1, 8'h40);
    ticks(2);
    expect_rd(3'd2, 8'hFF, "R7 lo idle"); expect_rd(3'd3, 8'h00, "R7 hi wrap"); expect_rd(3'd1, 8'hC0, "R7 flag1");
    wr(3'd1, 8'h10);
    ticks(1);
    expect_rd(3'd2, 8'h00, "R7 lo wrap"); expect_rd(3'd3, 8'h00, "R7 hi idle"); expect_rd(3'd1, 8'h30, "R7 flag0");
    wr(3'd1, 8'h00);

    // R9 channel 1 free-runs while channel 0 split
    wr(3'd0, 8'h13); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    ticks(2);
    expect_rd(3'd4, 8'h01, "R9"); expect_rd(3'd5, 8'h00, "R9");
    expect_rd(3'd1, 8'h00, "R9 no flag"); expect_rd(3'd3, 8'h00, "R9 hi0 needs run1");

    // R8 channel 1 hold
    wr(3'd0, 8'h30); wr(3'd1, 8'h40);
    ticks(5);
    expect_rd(3'd4, 8'h01, "R8"); expect_rd(3'd5, 8'h00, "R8"); expect_rd(3'd1, 8'h40, "R8");
    wr(3'd1, 8'h00);

    // R11 write beats step
    wr(3'd0, 8'h01); wr(3'd2, 8'h10); wr(3'd3, 8'h00); wr(3'd1, 8'h10);
    @(posedge clk); #1;
    mc_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h50;
    @(posedge clk); #1;
    mc_tick = 1'b0; wr_en = 1'b0;
    expect_rd(3'd2, 8'h50, "R11");
    ticks(1); expect_rd(3'd2, 8'h51, "R11 next step");
    wr(3'd1, 8'h00);

    // R10 hardware set beats software clear
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    @(posedge clk); #1;
    mc_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h10;
    @(posedge clk); #1;
    mc_tick = 1'b0; wr_en = 1'b0;
    expect_rd(3'd1, 8'h30, "R10 set wins");
    n_chk++;
    if (flags !== 2'b01) begin n_fail++; $display("FAIL R10 flags actual=%b expected=01", flags); end
    wr(3'd1, 8'h10); expect_rd(3'd1, 8'h10, "R10 clear");
    wr(3'd1, 8'h20); expect_rd(3'd1, 8'h20, "R10 sw set");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule